// File: doc/BRIEF.md
# Dual-Bank Paired Register File

This block keeps the operand storage for two processing elements, called X and Y. Each element owns a register file. Each file holds two banks of 16 registers, 40 bits wide: a primary bank and an alternate bank. A single bank-select state decides which bank both files use, so the two elements always switch context together. The select is a two-state machine (`BANK_PRI`, `BANK_ALT`). The transition `to_alt` fires on a select write carrying 1 while in `BANK_PRI`. The transition `to_pri` fires on a select write carrying 0 while in `BANK_ALT`. Every other cycle holds the state.

Each element has a set of combinational read ports for compute operands and one compute write port for results. A register-move path sits between the two files and takes an already decoded request. The request carries a source file, a destination file, two register indices, a condition-true flag and a lane-mode bit. In single-lane mode a move copies one register in one direction. In dual-lane mode the same request also drives a mirrored move with both file selects inverted. A cross-file request in dual-lane mode therefore exchanges the two registers. Both sources are read from the stored state before any write lands, so the exchange is exact.

Top module: `dual_bank_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the select is the primary bank and every register of both files in both banks reads as zero.
- R2: When `x_wr_en` is 1, `x_wr_data` is stored in file X, register `x_wr_idx`, of the active bank. Read ports show the new value from the next cycle on, because reads are combinational from stored state. The Y port works the same way on file Y, and neither port touches the other file.
- R3: The primary and alternate banks of each file are independent. A write to one bank leaves the same index in the other bank unchanged.
- R4: A cycle with `bank_we` at 1 loads `bank_alt` (0 = primary, 1 = alternate) as the select for both files. The new select takes effect in the next cycle. Reads in the same cycle still use the old bank. Without `bank_we` the select holds.
- R5: A single-lane move (`mv_dual` = 0) copies register `mv_src_idx` of the file named by `mv_src_y` to register `mv_dst_idx` of the file named by `mv_dst_y` (0 = X, 1 = Y). All four pairings are supported, and no other register changes.
- R6: A dual-lane move (`mv_dual` = 1) also copies register `mv_src_idx` of the file not named by `mv_src_y` into register `mv_dst_idx` of the file not named by `mv_dst_y`. Both sources are taken from the state before the write, so a cross-file request swaps the two values.
- R7: A move changes a register only when `mv_req` and `mv_cond` are both 1. Otherwise no register changes, and neither does any move destination.
- R8: When a compute write and a move target the same register in the same cycle, the move data is stored. A compute write to any other register still takes effect.
- R9: Compute writes and moves in a cycle with `bank_we` at 1 land in the bank that was active during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load a new bank select |
| bank_alt | input | 1 | Select value: 0 primary, 1 alternate |
| x_rd_idx | input | NRD*IDX_W | Packed read indices for file X, port p at bits p*IDX_W |
| x_rd_data | output | NRD*DATA_W | Packed read data for file X |
| y_rd_idx | input | NRD*IDX_W | Packed read indices for file Y |
| y_rd_data | output | NRD*DATA_W | Packed read data for file Y |
| x_wr_en | input | 1 | Compute write enable, file X |
| x_wr_idx | input | IDX_W | Compute write index, file X |
| x_wr_data | input | DATA_W | Compute write data, file X |
| y_wr_en | input | 1 | Compute write enable, file Y |
| y_wr_idx | input | IDX_W | Compute write index, file Y |
| y_wr_data | input | DATA_W | Compute write data, file Y |
| mv_req | input | 1 | Move request valid |
| mv_cond | input | 1 | Move condition is true |
| mv_dual | input | 1 | 1 = dual-lane move, 0 = single-lane |
| mv_src_y | input | 1 | Source file of the primary lane (0 X, 1 Y) |
| mv_dst_y | input | 1 | Destination file of the primary lane (0 X, 1 Y) |
| mv_src_idx | input | IDX_W | Source register index |
| mv_dst_idx | input | IDX_W | Destination register index |

## Verification
The properties assume that every control and index input holds a known value at each rising edge. They also assume that reset is asserted at time zero. The read-back properties compare a port against a value written one cycle earlier only when that port happens to address the written index. They therefore rely on no other path writing the same register: they exclude any colliding move and any bank change. The stimulus drives every input from the falling edge only, never leaves an input unknown, and holds reset from the very start. It mixes scripted collisions with long stretches of random traffic, so that both the excluded and the included cases occur.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
    typedef enum logic {
        BANK_PRI = 1'b0,
        BANK_ALT = 1'b1
    } bank_e;

    localparam int FILE_X = 0;
    localparam int FILE_Y = 1;
    localparam int NFILE  = 2;
    localparam int NBANK  = 2;
endpackage

// File: rtl/rf_bank_ctrl.sv
`timescale 1ns/1ps
module rf_bank_ctrl
    import rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_we,
    input  logic sel_alt,
    output logic bank_o
);
    bank_e state, state_nx;

    // transitions to_alt / to_pri
    always_comb begin
        state_nx = state;
        unique case (state)
            BANK_PRI: if (sel_we && sel_alt)  state_nx = BANK_ALT;
            BANK_ALT: if (sel_we && !sel_alt) state_nx = BANK_PRI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BANK_PRI;
        else        state <= state_nx;
    end

    always_comb begin
        bank_o = (state == BANK_ALT);
    end
endmodule

// File: rtl/rf_move_unit.sv
`timescale 1ns/1ps
module rf_move_unit
    import rf_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic              mv_req,
    input  logic              mv_cond,
    input  logic              mv_dual,
    input  logic              mv_src_y,
    input  logic              mv_dst_y,
    input  logic [DATA_W-1:0] src_data [NFILE],
    output logic              mw_en    [NFILE],
    output logic [DATA_W-1:0] mw_data  [NFILE]
);
    logic go;
    assign go = mv_req && mv_cond;

    for (genvar f = 0; f < NFILE; f++) begin : g_lane
        localparam logic FSEL = (f == FILE_Y);
        logic lane0_hit, lane1_hit;
        // primary lane lands here when the destination names this file,
        // mirrored lane when dual and the destination names the other file
        assign lane0_hit = (mv_dst_y == FSEL);
        assign lane1_hit = mv_dual && (mv_dst_y != FSEL);

        always_comb begin
            mw_en[f]   = go && (lane0_hit || lane1_hit);
            mw_data[f] = '0;
            if (lane0_hit)
                mw_data[f] = src_data[mv_src_y ? FILE_Y : FILE_X];
            else if (lane1_hit)
                mw_data[f] = src_data[mv_src_y ? FILE_X : FILE_Y];
        end
    end
endmodule

// File: rtl/rf_file.sv
`timescale 1ns/1ps
module rf_file
    import rf_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int NREG   = 16,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank,
    input  logic [NRD*IDX_W-1:0]  rd_idx,
    output logic [NRD*DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]      src_idx,
    output logic [DATA_W-1:0]     src_data,
    input  logic                  cw_en,
    input  logic [IDX_W-1:0]      cw_idx,
    input  logic [DATA_W-1:0]     cw_data,
    input  logic                  mw_en,
    input  logic [IDX_W-1:0]      mw_idx,
    input  logic [DATA_W-1:0]     mw_data
);
    logic [DATA_W-1:0] regs [NBANK][NREG];
    logic              cw_blocked;

    assign cw_blocked = mw_en && (mw_idx == cw_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int r = 0; r < NREG; r++)
                    regs[b][r] <= '0;
        end else begin
            if (cw_en && !cw_blocked) regs[bank][cw_idx] <= cw_data;
            if (mw_en)                regs[bank][mw_idx] <= mw_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p*DATA_W +: DATA_W] = regs[bank][rd_idx[p*IDX_W +: IDX_W]];
    end

    assign src_data = regs[bank][src_idx];
endmodule

// File: rtl/dual_bank_regfile.sv
`timescale 1ns/1ps
module dual_bank_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int NREG   = 16,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank_we,
    input  logic                  bank_alt,
    input  logic [NRD*IDX_W-1:0]  x_rd_idx,
    output logic [NRD*DATA_W-1:0] x_rd_data,
    input  logic [NRD*IDX_W-1:0]  y_rd_idx,
    output logic [NRD*DATA_W-1:0] y_rd_data,
    input  logic                  x_wr_en,
    input  logic [IDX_W-1:0]      x_wr_idx,
    input  logic [DATA_W-1:0]     x_wr_data,
    input  logic                  y_wr_en,
    input  logic [IDX_W-1:0]      y_wr_idx,
    input  logic [DATA_W-1:0]     y_wr_data,
    input  logic                  mv_req,
    input  logic                  mv_cond,
    input  logic                  mv_dual,
    input  logic                  mv_src_y,
    input  logic                  mv_dst_y,
    input  logic [IDX_W-1:0]      mv_src_idx,
    input  logic [IDX_W-1:0]      mv_dst_idx
);
    logic                  cur_bank;
    logic [DATA_W-1:0]     src_data [NFILE];
    logic                  mw_en    [NFILE];
    logic [DATA_W-1:0]     mw_data  [NFILE];
    logic                  cw_en    [NFILE];
    logic [IDX_W-1:0]      cw_idx   [NFILE];
    logic [DATA_W-1:0]     cw_data  [NFILE];
    logic [NRD*IDX_W-1:0]  rd_idx   [NFILE];
    logic [NRD*DATA_W-1:0] rd_data  [NFILE];

    rf_bank_ctrl u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_we (bank_we),
        .sel_alt(bank_alt),
        .bank_o (cur_bank)
    );

    rf_move_unit #(.DATA_W(DATA_W)) u_move (
        .mv_req  (mv_req),
        .mv_cond (mv_cond),
        .mv_dual (mv_dual),
        .mv_src_y(mv_src_y),
        .mv_dst_y(mv_dst_y),
        .src_data(src_data),
        .mw_en   (mw_en),
        .mw_data (mw_data)
    );

    assign cw_en[FILE_X]   = x_wr_en;
    assign cw_idx[FILE_X]  = x_wr_idx;
    assign cw_data[FILE_X] = x_wr_data;
    assign rd_idx[FILE_X]  = x_rd_idx;
    assign cw_en[FILE_Y]   = y_wr_en;
    assign cw_idx[FILE_Y]  = y_wr_idx;
    assign cw_data[FILE_Y] = y_wr_data;
    assign rd_idx[FILE_Y]  = y_rd_idx;
    assign x_rd_data       = rd_data[FILE_X];
    assign y_rd_data       = rd_data[FILE_Y];

    for (genvar f = 0; f < NFILE; f++) begin : g_file
        rf_file #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_file (
            .clk     (clk),
            .rst_n   (rst_n),
            .bank    (cur_bank),
            .rd_idx  (rd_idx[f]),
            .rd_data (rd_data[f]),
            .src_idx (mv_src_idx),
            .src_data(src_data[f]),
            .cw_en   (cw_en[f]),
            .cw_idx  (cw_idx[f]),
            .cw_data (cw_data[f]),
            .mw_en   (mw_en[f]),
            .mw_idx  (mv_dst_idx),
            .mw_data (mw_data[f])
        );
    end
endmodule

// File: rtl/rf_checks.sv
`timescale 1ns/1ps
module rf_checks #(
    parameter int DATA_W = 40,
    parameter int NREG   = 16,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cur_bank,
    input logic                  bank_we,
    input logic                  bank_alt,
    input logic [NRD*IDX_W-1:0]  x_rd_idx,
    input logic [NRD*DATA_W-1:0] x_rd_data,
    input logic [NRD*IDX_W-1:0]  y_rd_idx,
    input logic [NRD*DATA_W-1:0] y_rd_data,
    input logic                  x_wr_en,
    input logic [IDX_W-1:0]      x_wr_idx,
    input logic [DATA_W-1:0]     x_wr_data,
    input logic                  y_wr_en,
    input logic [IDX_W-1:0]      y_wr_idx,
    input logic [DATA_W-1:0]     y_wr_data,
    input logic                  mv_req,
    input logic                  mv_cond,
    input logic                  mv_dual,
    input logic                  mv_dst_y,
    input logic [IDX_W-1:0]      mv_dst_idx
);
    logic mv_go, hit_x, hit_y;
    assign mv_go = mv_req && mv_cond;
    assign hit_x = mv_go && (!mv_dst_y || mv_dual) && (mv_dst_idx == x_wr_idx);
    assign hit_y = mv_go && (mv_dst_y || mv_dual) && (mv_dst_idx == y_wr_idx);

    a_r1_reset_primary: assert property (@(posedge clk)
        !rst_n |=> (cur_bank == 1'b0));

    a_r4_select_loads: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (cur_bank == $past(bank_alt)));

    a_r4_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(cur_bank));

    a_r2_x_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (x_wr_en && !hit_x && !bank_we) |=>
        (x_rd_idx[IDX_W-1:0] != $past(x_wr_idx) ||
         x_rd_data[DATA_W-1:0] == $past(x_wr_data)));

    a_r2_y_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr_en && !hit_y && !bank_we) |=>
        (y_rd_idx[IDX_W-1:0] != $past(y_wr_idx) ||
         y_rd_data[DATA_W-1:0] == $past(y_wr_data)));

    a_r7_quiet_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_wr_en && !y_wr_en && !mv_go && !bank_we) |=>
        (!$stable(x_rd_idx) || $stable(x_rd_data)));

    a_r7_quiet_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_wr_en && !y_wr_en && !mv_go && !bank_we) |=>
        (!$stable(y_rd_idx) || $stable(y_rd_data)));
endmodule

bind dual_bank_regfile rf_checks #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_bank  (cur_bank),
    .bank_we   (bank_we),
    .bank_alt  (bank_alt),
    .x_rd_idx  (x_rd_idx),
    .x_rd_data (x_rd_data),
    .y_rd_idx  (y_rd_idx),
    .y_rd_data (y_rd_data),
    .x_wr_en   (x_wr_en),
    .x_wr_idx  (x_wr_idx),
    .x_wr_data (x_wr_data),
    .y_wr_en   (y_wr_en),
    .y_wr_idx  (y_wr_idx),
    .y_wr_data (y_wr_data),
    .mv_req    (mv_req),
    .mv_cond   (mv_cond),
    .mv_dual   (mv_dual),
    .mv_dst_y  (mv_dst_y),
    .mv_dst_idx(mv_dst_idx)
);

// File: tb/sim_dual_bank_regfile.sv
`timescale 1ns/1ps
module sim_dual_bank_regfile;
    localparam int DW  = 40;
    localparam int NR  = 16;
    localparam int NP  = 2;
    localparam int IW  = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bank_we, bank_alt;
    logic [NP*IW-1:0] x_rd_idx, y_rd_idx;
    logic [NP*DW-1:0] x_rd_data, y_rd_data;
    logic           x_wr_en, y_wr_en;
    logic [IW-1:0]  x_wr_idx, y_wr_idx;
    logic [DW-1:0]  x_wr_data, y_wr_data;
    logic           mv_req, mv_cond, mv_dual, mv_src_y, mv_dst_y;
    logic [IW-1:0]  mv_src_idx, mv_dst_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // reference state: [file][bank][register]
    logic [DW-1:0] mdl [2][2][NR];
    int            mbank = 0;

    always #2 clk = ~clk;

    dual_bank_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_alt(bank_alt),
        .x_rd_idx(x_rd_idx), .x_rd_data(x_rd_data),
        .y_rd_idx(y_rd_idx), .y_rd_data(y_rd_data),
        .x_wr_en(x_wr_en), .x_wr_idx(x_wr_idx), .x_wr_data(x_wr_data),
        .y_wr_en(y_wr_en), .y_wr_idx(y_wr_idx), .y_wr_data(y_wr_data),
        .mv_req(mv_req), .mv_cond(mv_cond), .mv_dual(mv_dual),
        .mv_src_y(mv_src_y), .mv_dst_y(mv_dst_y),
        .mv_src_idx(mv_src_idx), .mv_dst_idx(mv_dst_idx)
    );

    function automatic logic [DW-1:0] rnd40();
        logic [63:0] w;
        w = {$urandom, $urandom};
        return w[DW-1:0];
    endfunction

    task automatic clear_strobes();
        x_wr_en = 1'b0; y_wr_en = 1'b0; mv_req = 1'b0; mv_cond = 1'b0;
        mv_dual = 1'b0; bank_we = 1'b0;
    endtask

    // compare reads against the model, advance the model, move to next falling edge
    task automatic cyc();
        logic [DW-1:0] sx, sy, got, exp;
        logic [IW-1:0] ri;
        int f0, f1;
        #1;
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < NP; p++) begin
                ri  = (f == 0) ? x_rd_idx[p*IW +: IW] : y_rd_idx[p*IW +: IW];
                got = (f == 0) ? x_rd_data[p*DW +: DW] : y_rd_data[p*DW +: DW];
                exp = mdl[f][mbank][ri];
                checks++;
                if (got !== exp) begin
                    fails++;
                    $display("FAIL %s file=%0d port=%0d idx=%0d actual=%h expected=%h",
                             tag, f, p, ri, got, exp);
                end
            end
        end
        if (rst_n) begin
            sx = mdl[0][mbank][mv_src_idx];
            sy = mdl[1][mbank][mv_src_idx];
            if (x_wr_en) mdl[0][mbank][x_wr_idx] = x_wr_data;
            if (y_wr_en) mdl[1][mbank][y_wr_idx] = y_wr_data;
            if (mv_req && mv_cond) begin
                f0 = mv_dst_y ? 1 : 0;
                mdl[f0][mbank][mv_dst_idx] = mv_src_y ? sy : sx;
                if (mv_dual) begin
                    f1 = 1 - f0;
                    mdl[f1][mbank][mv_dst_idx] = mv_src_y ? sx : sy;
                end
            end
            if (bank_we) mbank = bank_alt ? 1 : 0;
        end
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic sweep();
        for (int i = 0; i < NR / NP; i++) begin
            x_rd_idx = {IW'(2*i+1), IW'(2*i)};
            y_rd_idx = {IW'(2*i+1), IW'(2*i)};
            cyc();
        end
    endtask

    task automatic cwrite(input int f, input int idx, input logic [DW-1:0] d);
        if (f == 0) begin x_wr_en = 1'b1; x_wr_idx = IW'(idx); x_wr_data = d; end
        else        begin y_wr_en = 1'b1; y_wr_idx = IW'(idx); y_wr_data = d; end
    endtask

    task automatic move(input bit cond, input bit dual, input bit sy, input bit dy,
                        input int si, input int di);
        mv_req = 1'b1; mv_cond = cond; mv_dual = dual; mv_src_y = sy; mv_dst_y = dy;
        mv_src_idx = IW'(si); mv_dst_idx = IW'(di);
    endtask

    initial begin
        rst_n = 1'b0;
        clear_strobes();
        bank_alt = 1'b0; x_rd_idx = '0; y_rd_idx = '0;
        x_wr_idx = '0; y_wr_idx = '0; x_wr_data = '0; y_wr_data = '0;
        mv_src_y = 1'b0; mv_dst_y = 1'b0; mv_src_idx = '0; mv_dst_idx = '0;
        for (int f = 0; f < 2; f++)
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < NR; r++) mdl[f][b][r] = '0;

        // R1: reset state, including a write attempt while reset is held
        tag = "R1";
        @(negedge clk);
        cwrite(0, 3, 40'hAA_0000_0001);
        cyc();
        sweep();
        rst_n = 1'b1;
        sweep();
        bank_we = 1'b1; bank_alt = 1'b1; cyc();
        sweep();
        bank_we = 1'b1; bank_alt = 1'b0; cyc();

        // R2: compute writes in both files, distinct patterns
        tag = "R2";
        for (int i = 0; i < NR; i++) begin
            cwrite(0, i, 40'h10_0000_0000 + DW'(i));
            cwrite(1, NR - 1 - i, 40'hF0_0000_0000 | DW'(i << 8));
            x_rd_idx = {IW'(i), IW'(i)}; y_rd_idx = {IW'(i), IW'(NR - 1 - i)};
            cyc();
        end
        sweep();

        // R3/R4: alternate bank is separate, switch is seen one cycle later
        tag = "R4";
        x_rd_idx = {IW'(1), IW'(0)}; y_rd_idx = {IW'(1), IW'(0)};
        bank_we = 1'b1; bank_alt = 1'b1; cyc();
        cyc();
        tag = "R3";
        sweep();
        for (int i = 0; i < NR; i += 3) begin
            cwrite(0, i, rnd40()); cwrite(1, i, rnd40()); cyc();
        end
        sweep();
        tag = "R4";
        bank_we = 1'b1; bank_alt = 1'b0; cyc();
        tag = "R3";
        sweep();
        tag = "R4";
        bank_we = 1'b1; bank_alt = 1'b0; cyc();
        sweep();

        // R5: the four single-lane pairings
        tag = "R5";
        for (int c = 0; c < 4; c++) begin
            move(1'b1, 1'b0, c[1], c[0], c + 2, 9 + c);
            cyc();
            sweep();
        end

        // R6: dual-lane, cross-file swap and same-file parallel copy
        tag = "R6";
        move(1'b1, 1'b1, 1'b0, 1'b1, 5, 5); cyc();
        sweep();
        move(1'b1, 1'b1, 1'b1, 1'b0, 7, 4); cyc();
        sweep();
        move(1'b1, 1'b1, 1'b0, 1'b0, 1, 14); cyc();
        sweep();
        move(1'b1, 1'b1, 1'b1, 1'b1, 2, 13); cyc();
        sweep();

        // R7: request without condition, condition without request
        tag = "R7";
        move(1'b0, 1'b1, 1'b0, 1'b1, 3, 8); cyc();
        sweep();
        move(1'b0, 1'b0, 1'b1, 1'b0, 6, 6); cyc();
        sweep();
        mv_req = 1'b0; mv_cond = 1'b1; mv_dual = 1'b1; mv_dst_idx = 4'd0; cyc();
        sweep();

        // R8: move and compute write collide; other compute write survives
        tag = "R8";
        move(1'b1, 1'b0, 1'b1, 1'b0, 11, 6);
        cwrite(0, 6, 40'hDE_AD00_0006);
        cwrite(1, 12, 40'h12_3400_000C);
        cyc();
        sweep();
        move(1'b1, 1'b1, 1'b0, 1'b1, 0, 15);
        cwrite(0, 15, 40'h55_5500_0000);
        cwrite(1, 15, 40'h66_6600_0000);
        cyc();
        sweep();

        // R9: writes in the switching cycle go to the old bank
        tag = "R9";
        bank_we = 1'b1; bank_alt = 1'b1;
        cwrite(0, 10, 40'h99_0000_000A);
        move(1'b1, 1'b0, 1'b0, 1'b1, 10, 3);
        cyc();
        sweep();
        bank_we = 1'b1; bank_alt = 1'b0;
        cwrite(1, 8, 40'h77_0000_0008);
        cyc();
        sweep();

        // mixed random traffic across every feature
        tag = "R6";
        for (int n = 0; n < 3000; n++) begin
            x_rd_idx = IW*NP'($urandom); y_rd_idx = IW*NP'($urandom);
            if (($urandom % 3) == 0) cwrite(0, int'($urandom % NR), rnd40());
            if (($urandom % 3) == 0) cwrite(1, int'($urandom % NR), rnd40());
            if (($urandom % 2) == 0)
                move(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     int'($urandom % NR), int'($urandom % NR));
            if (($urandom % 9) == 0) begin bank_we = 1'b1; bank_alt = 1'($urandom); end
            cyc();
        end
        sweep();
        bank_we = 1'b1; bank_alt = ~bank_alt; cyc();
        sweep();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog %s actual=hung expected=finished", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule